// File: doc/BRIEF.md
# Latched Interrupt Status Controller

This block collects seven event lines from the overhead and test-pattern monitors of a multi-loop framer and demultiplexer. It keeps a sticky record of each event in an interrupt status register, and it lets software choose, through an interrupt enable register, which recorded events raise a single interrupt request. Both registers sit on a simple synchronous register bus. The bus has an address, a write strobe, write data and combinational read data.

A status bit goes high as soon as its event line is seen high on a clock edge. It stays high until software writes a one to that bit position. That write only clears the bit if the event line has already dropped; if the event is still present, the bit stays set. Events are recorded whatever the enable setting is. The enables only decide which recorded bits reach the interrupt request.

Top module: `lisc_irq_ctrl`

## Requirements
- R1: While the internal reset is active and after it, until the first event or write, both registers read 0x00 and `irq_out` is low. The internal reset is asserted asynchronously by `rst_n` low and is released two rising clock edges after `rst_n` rises.
- R2: A write to address 0x1B stores `bus_wdata[6:0]` in the enable register. A read of 0x1B returns it, with bit 7 reading zero.
- R3: A status bit is set on any clock edge at which its event line is high. It then stays high after the event line returns low.
- R4: A write to address 0x1C clears each status bit whose write-data bit is one and whose event line is low on that edge. Write-data bits of zero leave their status bits unchanged.
- R5: A clearing write is ignored for a bit whose event line is high on that same edge, so the bit stays set.
- R6: Status bits latch events whether or not their enable bit is set.
- R7: `irq_out` is high exactly when some bit is set in both the status register and the enable register. It follows register updates with no added delay.
- R8: Bit 7 of both registers always reads zero. Reads of any address other than 0x1B and 0x1C return 0x00, and writes to such addresses change nothing.
- R9: Bit positions are fixed. `evt_in[0]`, `evt_in[1]` and `evt_in[2]` are the loop 1, loop 2 and loop 3 indicator-bit events. `evt_in[3]` is loop power status. `evt_in[4]` is loss of signal on any loop. `evt_in[5]` is pattern error counter overflow. `evt_in[6]` is pattern sync loss. Each event lands in the same bit position of the status and enable registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one write per clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| evt_in | input | 7 | Event lines, level sensitive, see R9 |
| irq_out | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit bus, seven event lines, and the enable and status registers at 0x1B and 0x1C. With this build, random traffic that mixes both register addresses with unmapped ones reaches every bit position. It also reaches the same-edge collision between a set and a clearing write. Directed cases pin down that collision, zero-valued clear writes, the unused top bit and reset release.

// File: rtl/lisc_pkg.sv
package lisc_pkg;
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_ENA  = 2'd1,
    SEL_STAT = 2'd2
  } reg_sel_e;
endpackage

// File: rtl/lisc_rst_sync.sv
module lisc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

  assert_held_low_R1: assert property (@(posedge clk) !rst_n |=> !rst_sync_n);
endmodule

// File: rtl/lisc_addr_dec.sv
module lisc_addr_dec
  import lisc_pkg::*;
#(
  parameter int          ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] ENA_ADDR  = 8'h1B,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h1C
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  always_comb begin
    if (addr == ENA_ADDR)       sel = SEL_ENA;
    else if (addr == STAT_ADDR) sel = SEL_STAT;
    else                        sel = SEL_NONE;
  end
endmodule

// File: rtl/lisc_stat_bit.sv
module lisc_stat_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr_req,
  output logic stat_q
);
  logic stat_d;
  logic stat_en;

  always_comb begin
    stat_en = evt | clr_req;
    stat_d  = evt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= 1'b0;
    else if (stat_en) stat_q <= stat_d;
  end

  assert_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> stat_q);
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_req && !evt) |=> !stat_q);
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !(clr_req && !evt)) |=> stat_q);
endmodule

// File: rtl/lisc_enable_reg.sv
module lisc_enable_reg #(
  parameter int N_EVT = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [N_EVT-1:0] wdata,
  output logic [N_EVT-1:0] ena_q
);
  logic [N_EVT-1:0] ena_d;

  always_comb begin
    ena_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ena_q <= '0;
    else if (wr_en) ena_q <= ena_d;
  end

  assert_ena_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ena_q == $past(wdata)));
  assert_ena_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ena_q));
endmodule

// File: rtl/lisc_irq_ctrl.sv
module lisc_irq_ctrl
  import lisc_pkg::*;
#(
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 8,
  parameter int                N_EVT     = 7,
  parameter logic [ADDR_W-1:0] ENA_ADDR  = 8'h1B,
  parameter logic [ADDR_W-1:0] STAT_ADDR = 8'h1C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_EVT-1:0]  evt_in,
  output logic              irq_out
);
  localparam int PAD_W = DATA_W - N_EVT;

  logic             rst_int_n;
  reg_sel_e         sel;
  logic             ena_wr;
  logic             stat_wr;
  logic [N_EVT-1:0] ena_q;
  logic [N_EVT-1:0] stat_q;
  logic [N_EVT-1:0] clr_req;

  lisc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lisc_addr_dec #(
    .ADDR_W    (ADDR_W),
    .ENA_ADDR  (ENA_ADDR),
    .STAT_ADDR (STAT_ADDR)
  ) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  always_comb begin
    ena_wr  = bus_wr && (sel == SEL_ENA);
    stat_wr = bus_wr && (sel == SEL_STAT);
    clr_req = stat_wr ? bus_wdata[N_EVT-1:0] : '0;
  end

  lisc_enable_reg #(.N_EVT(N_EVT)) u_ena (
    .clk   (clk),
    .rst_n (rst_int_n),
    .wr_en (ena_wr),
    .wdata (bus_wdata[N_EVT-1:0]),
    .ena_q (ena_q)
  );

  for (genvar i = 0; i < N_EVT; i++) begin : g_stat
    lisc_stat_bit u_bit (
      .clk     (clk),
      .rst_n   (rst_int_n),
      .evt     (evt_in[i]),
      .clr_req (clr_req[i]),
      .stat_q  (stat_q[i])
    );
  end

  always_comb begin
    unique case (sel)
      SEL_ENA:  bus_rdata = {{PAD_W{1'b0}}, ena_q};
      SEL_STAT: bus_rdata = {{PAD_W{1'b0}}, stat_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq_out = |(stat_q & ena_q);

  assert_irq_off_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ena_wr && bus_wdata[N_EVT-1:0] == '0) |=> !irq_out);
  assert_irq_on_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (ena_wr && |(bus_wdata[N_EVT-1:0] & evt_in)) |=> irq_out);
  assert_latch_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (evt_in != '0) |=> (stat_q != '0));
  assert_top_bit_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    bus_rdata[DATA_W-1] == 1'b0);
  assert_unmapped_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    (sel == SEL_NONE) |-> (bus_rdata == '0));
endmodule

// File: tb/tb_lisc_irq_ctrl.sv
module tb_lisc_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = 8'h00;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [6:0] evt_in = 7'h00;
  logic       irq_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [6:0] m_ena = 7'h00;
  logic [6:0] m_stat = 7'h00;

  lisc_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .irq_out(irq_out)
  );

  always #10 clk = ~clk;

  function automatic logic [7:0] exp_rd(input logic [7:0] a);
    if (a == 8'h1B) return {1'b0, m_ena};
    if (a == 8'h1C) return {1'b0, m_stat};
    return 8'h00;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  // drive at negedge, model updates at posedge, check 1 ns later
  task automatic step(input logic [7:0] a, input logic wr, input logic [7:0] wd,
                      input logic [6:0] ev, input string req);
    logic [6:0] clr;
    @(negedge clk);
    bus_addr = a; bus_wr = wr; bus_wdata = wd; evt_in = ev;
    @(posedge clk);
    clr = (wr && a == 8'h1C) ? wd[6:0] : 7'h00;
    if (wr && a == 8'h1B) m_ena = wd[6:0];
    m_stat = (m_stat & ~(clr & ~ev)) | ev;
    #1;
    chk(req, bus_rdata, exp_rd(a));
    chk({req, " irq R7"}, {7'h0, irq_out}, {7'h0, |(m_stat & m_ena)});
  endtask

  task automatic idle_rd(input logic [7:0] a, input string req);
    step(a, 1'b0, 8'h00, 7'h00, req);
  endtask

  function automatic logic [7:0] pick_addr(input int unsigned r);
    case (r % 4)
      0: return 8'h1B;
      1, 2: return 8'h1C;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    int unsigned seed;
    seed = $urandom(32'd1234);
    // R1 reset state
    #5;
    chk("R1 ena in reset", bus_rdata, 8'h00);
    bus_addr = 8'h1C; #1;
    chk("R1 stat in reset", bus_rdata, 8'h00);
    chk("R1 irq in reset", {7'h0, irq_out}, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(posedge clk); @(posedge clk);
    idle_rd(8'h1B, "R1 ena after reset");
    idle_rd(8'h1C, "R1 stat after reset");

    // R2 enable write, bit 7 dropped
    step(8'h1B, 1'b1, 8'hFF, 7'h00, "R2 ena write ff");
    idle_rd(8'h1B, "R2 ena readback");
    step(8'h1B, 1'b1, 8'h00, 7'h00, "R2 ena write 00");

    // R3, R6, R9: each line latches into its own bit, with enables clear
    for (int i = 0; i < 7; i++) begin
      step(8'h1C, 1'b0, 8'h00, 7'(1 << i), "R9 bit position");
      idle_rd(8'h1C, "R3 latched after event drop");
      chk("R6 latched while disabled", {1'b0, m_stat}, {1'b0, 7'(1 << i) | m_stat});
      step(8'h1C, 1'b1, 8'h7F, 7'h00, "R4 clear all");
    end

    // R4 zero write keeps bits
    step(8'h1C, 1'b0, 8'h00, 7'h55, "R3 set 55");
    step(8'h1C, 1'b1, 8'h00, 7'h00, "R4 zero write no effect");
    step(8'h1C, 1'b1, 8'h05, 7'h00, "R4 partial clear");
    idle_rd(8'h1C, "R4 remaining bits");

    // R5 clear while source active
    step(8'h1C, 1'b1, 8'h7F, 7'h10, "R5 clear with active source");
    idle_rd(8'h1C, "R5 bit held");
    step(8'h1C, 1'b1, 8'h7F, 7'h00, "R4 clear after source drop");

    // R7 irq gating
    step(8'h1C, 1'b0, 8'h00, 7'h20, "R7 set bit5");
    step(8'h1B, 1'b1, 8'h10, 7'h00, "R7 other enable only");
    step(8'h1B, 1'b1, 8'h20, 7'h00, "R7 matching enable");
    step(8'h1B, 1'b1, 8'h00, 7'h00, "R7 enable removed");

    // R8 unmapped access
    step(8'h1D, 1'b1, 8'hFF, 7'h00, "R8 unmapped write");
    idle_rd(8'h1B, "R8 ena unchanged");
    idle_rd(8'h1C, "R8 stat unchanged");
    step(8'h1B, 1'b1, 8'h80, 7'h00, "R8 bit7 of ena");
    step(8'h1C, 1'b1, 8'h80, 7'h00, "R8 bit7 of stat");

    // random traffic
    for (int n = 0; n < 400; n++) begin
      logic [7:0] a;
      logic [6:0] ev;
      a  = pick_addr($urandom);
      ev = (($urandom % 4) == 0) ? 7'($urandom) & 7'($urandom) : 7'h00;
      step(a, 1'($urandom), 8'($urandom), ev, "R3 R4 R5 R7 random");
    end

    // reset mid-run clears both registers (R1)
    @(negedge clk); rst_n = 1'b0; #1;
    m_ena = 7'h00; m_stat = 7'h00;
    bus_addr = 8'h1C; bus_wr = 1'b0; evt_in = 7'h00; #1;
    chk("R1 async reset stat", bus_rdata, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); @(posedge clk);
    idle_rd(8'h1B, "R1 ena after second reset");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule